// File: doc/BRIEF.md
# Parallel flash command interpreter

This block is the device-side command engine of a byte-wide parallel NOR flash. A host drives a simple synchronous bus (address, write data, write strobe, read strobe) and the block decodes command bytes written on it. The decoded commands select what a read returns (array contents, identifier and lock information, or a status byte) and start program, erase and lock operations on a small internal memory array.

Program, erase and lock changes are two-write sequences: a first byte arms the operation and the second byte confirms it or supplies data. Every launched operation holds the device busy for a fixed number of cycles. While busy, the status byte reports not-ready and every write except the status-read command is ignored. Each block carries a lock bit. A master lock bit, once set, makes the clear-all-locks command fail. Errors are recorded in sticky status flags until the host clears them. A parameter picks the block layout. One layout is uniform large blocks. The other splits the first large block into eight small blocks.

Top module: `pflash_cmd_core`

## Requirements
- R1: After reset the block is in array-read mode, bus_rvalid is low with no read pending, and the status byte reads 0x80.
- R2: Byte 0xFF selects array-read mode, where a read returns the stored byte. A read strobe at clock edge N gives bus_rvalid high and valid bus_rdata after edge N+2.
- R3: Byte 0x90 selects identifier mode. Reads return values by offset from the base of the addressed block: offset 0 gives MFR_ID, which has odd parity; offset 1 gives DEV_ID; offset 2 gives 0x01 if that block is locked, else 0x00; offset 3 gives 0x01 if the master lock is set, else 0x00; every other offset gives 0x00.
- R4: Byte 0x70 selects status mode. The status bits are: bit 7 is ready (1) or busy (0), bit 5 is erase error, bit 4 is program error, and bit 1 is lock/abort error. Bits 6, 3, 2 and 0 always read 0.
- R5: Byte 0x40 followed by a data write programs the byte at the second write's address to old AND data. The operation is busy for PROG_CYCLES cycles and leaves the block in status mode.
- R6: Byte 0x20 followed by 0xD0 at an address inside a block sets every byte of that block to 0xFF and leaves other blocks unchanged. It is busy for the block size plus ERASE_TAIL cycles.
- R7: Byte 0x60 followed by 0xD0 clears all block locks, but only while the master lock is clear. If the master lock is set, it instead sets status bits 5 and 1 and leaves the locks unchanged. 0x60 followed by 0x01 locks the addressed block. 0x60 followed by 0xF1 sets the master lock, which only reset clears. Each accepted lock operation is busy for LOCK_CYCLES cycles.
- R8: Program or erase aimed at a locked block sets status bit 1 together with bit 4 (program) or bit 5 (erase), leaves the array unchanged, and does not go busy.
- R9: After 0x20 or 0x60, a second byte that is not a valid confirm sets status bits 4 and 5 and changes nothing else.
- R10: Byte 0x50 clears status bits 5, 4 and 1 and does not change the read mode. Error bits otherwise stay set.
- R11: While busy, status bit 7 reads 0 and writes other than 0x70 are ignored. A busy operation launched at edge E reads busy for a status read sampled at edge E+N and ready for one sampled at edge E+N+1, where N is its busy length.
- R12: With BOOT_LAYOUT=1, the first LARGE_SZ bytes form eight blocks of LARGE_SZ/8 bytes, numbered 0 to 7, and the remaining large blocks are numbered from 8. With BOOT_LAYOUT=0, all blocks are LARGE_SZ bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 8 | Command or data byte |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read result, registered |
| bus_rvalid | output | 1 | High for one cycle when bus_rdata holds a read result |

## Verification
A wrong command phase or read mode shows at the ports on the very next read. That read, two cycles after its strobe, returns a status byte, identifier value or array byte where a different one was due. A lock or error flag in the wrong state stays hidden until a status or identifier read, or until a later program or erase succeeds or fails against expectation. Array corruption from a misplaced erase or read-modify-write therefore appears only when the affected and neighbouring addresses are read back. For that reason the directed scenarios read both the target byte and the bytes just across each block boundary. A busy counter that is off by one shows in a single status read taken on the exact edge where ready is due.

// File: rtl/pflash_cmd_pkg.sv
package pflash_cmd_pkg;

  typedef enum logic [1:0] {RD_ARRAY, RD_IDENT, RD_STATUS} rd_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ARM_PROG, PH_ARM_ERASE, PH_ARM_LOCK, PH_RUN
  } phase_e;

  typedef struct packed {
    logic erase;
    logic prog;
    logic lock;
  } err_t;

  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
  localparam logic [7:0] OP_IDENT      = 8'h90;
  localparam logic [7:0] OP_STATUS     = 8'h70;
  localparam logic [7:0] OP_CLR_STATUS = 8'h50;
  localparam logic [7:0] OP_PROGRAM    = 8'h40;
  localparam logic [7:0] OP_ERASE      = 8'h20;
  localparam logic [7:0] OP_LOCK       = 8'h60;
  localparam logic [7:0] OP_CONFIRM    = 8'hD0;
  localparam logic [7:0] OP_LOCK_SET   = 8'h01;
  localparam logic [7:0] OP_MASTER_SET = 8'hF1;

  localparam int ST_READY     = 7;
  localparam int ST_ERASE_ERR = 5;
  localparam int ST_PROG_ERR  = 4;
  localparam int ST_LOCK_ERR  = 1;

endpackage

// File: rtl/pflash_blk_map.sv
module pflash_blk_map #(
  parameter int ADDR_W      = 8,
  parameter int LARGE_SZ    = 64,
  parameter int BOOT_LAYOUT = 1,
  parameter int BLK_W       = 4,
  parameter int LEN_W       = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BLK_W-1:0]  blk,
  output logic [ADDR_W-1:0] base,
  output logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] off
);
  localparam int SMALL_SZ = LARGE_SZ / 8;
  localparam int LARGE_SH = $clog2(LARGE_SZ);
  localparam int SMALL_SH = $clog2(SMALL_SZ);

  generate
    if (BOOT_LAYOUT != 0) begin : g_boot
      // R12: first large block split into eight small ones
      always_comb begin
        if (addr < ADDR_W'(LARGE_SZ)) begin
          blk  = BLK_W'(addr >> SMALL_SH);
          base = addr & ~ADDR_W'(SMALL_SZ - 1);
          len  = LEN_W'(SMALL_SZ);
        end else begin
          blk  = BLK_W'(addr >> LARGE_SH) + BLK_W'(7);
          base = addr & ~ADDR_W'(LARGE_SZ - 1);
          len  = LEN_W'(LARGE_SZ);
        end
      end
    end else begin : g_uniform
      always_comb begin
        blk  = BLK_W'(addr >> LARGE_SH);
        base = addr & ~ADDR_W'(LARGE_SZ - 1);
        len  = LEN_W'(LARGE_SZ);
      end
    end
  endgenerate

  assign off = addr - base;

endmodule

// File: rtl/pflash_array.sv
module pflash_array #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 2 ** ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];

  // Power-up image: erased cells
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pflash_ctrl.sv
module pflash_ctrl
  import pflash_cmd_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int NBLK          = 11,
  parameter int BLK_W         = 4,
  parameter int LEN_W         = 7,
  parameter int CNT_W         = 7,
  parameter int PROG_CYCLES   = 5,
  parameter int ERASE_TAIL    = 4,
  parameter int LOCK_CYCLES   = 3,
  parameter int LOCK_AT_RESET = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BLK_W-1:0]  map_blk,
  input  logic [ADDR_W-1:0] map_base,
  input  logic [LEN_W-1:0]  map_len,
  input  logic [7:0]        mem_q,
  output rd_mode_e          mode,
  output logic [7:0]        status,
  output logic [NBLK-1:0]   locks,
  output logic              master_lock,
  output logic              busy,
  output logic              armed,
  output err_t              err_bits,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              op_locked
);
  phase_e            phase;
  rd_mode_e          mode_q;
  logic [CNT_W-1:0]  cnt;
  err_t              err;
  logic [NBLK-1:0]   lock_q;
  logic              master_q;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data;
  logic [BLK_W-1:0]  op_blk;
  logic              rmw1, rmw2;
  logic              er_on;
  logic [LEN_W-1:0]  er_ptr, er_len;
  logic              tgt_locked;

  assign tgt_locked = lock_q[map_blk];
  assign busy       = (phase == PH_RUN);
  assign armed      = (phase != PH_IDLE) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      mode_q   <= RD_ARRAY;
      cnt      <= '0;
      err      <= '0;
      lock_q   <= {NBLK{LOCK_AT_RESET != 0}};
      master_q <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
      op_blk   <= '0;
      rmw1     <= 1'b0;
      rmw2     <= 1'b0;
      er_on    <= 1'b0;
      er_ptr   <= '0;
      er_len   <= '0;
    end else begin
      rmw2 <= rmw1;
      rmw1 <= 1'b0;
      if (er_on) begin
        er_ptr <= er_ptr + 1'b1;
        if (er_ptr == er_len - 1'b1) er_on <= 1'b0;
      end
      if (busy) begin
        // R11: countdown, all writes ignored
        if (cnt == '0) phase <= PH_IDLE;
        else           cnt   <= cnt - 1'b1;
      end else if (bus_we) begin
        case (phase)
          PH_IDLE: begin
            case (bus_wdata)
              OP_READ_ARRAY: mode_q <= RD_ARRAY;
              OP_IDENT:      mode_q <= RD_IDENT;
              OP_STATUS:     mode_q <= RD_STATUS;
              OP_CLR_STATUS: err    <= '0;
              OP_PROGRAM:    phase  <= PH_ARM_PROG;
              OP_ERASE:      phase  <= PH_ARM_ERASE;
              OP_LOCK:       phase  <= PH_ARM_LOCK;
              default:       ;
            endcase
          end
          PH_ARM_PROG: begin
            mode_q <= RD_STATUS;
            phase  <= PH_IDLE;
            if (tgt_locked) begin
              err.prog <= 1'b1;
              err.lock <= 1'b1;
            end else begin
              phase   <= PH_RUN;
              cnt     <= CNT_W'(PROG_CYCLES - 1);
              op_addr <= bus_addr;
              op_data <= bus_wdata;
              op_blk  <= map_blk;
              rmw1    <= 1'b1;
            end
          end
          PH_ARM_ERASE: begin
            mode_q <= RD_STATUS;
            phase  <= PH_IDLE;
            if (bus_wdata != OP_CONFIRM) begin
              err.erase <= 1'b1;
              err.prog  <= 1'b1;
            end else if (tgt_locked) begin
              err.erase <= 1'b1;
              err.lock  <= 1'b1;
            end else begin
              phase   <= PH_RUN;
              cnt     <= CNT_W'(map_len) + CNT_W'(ERASE_TAIL) - 1'b1;
              op_addr <= map_base;
              op_blk  <= map_blk;
              er_len  <= map_len;
              er_ptr  <= '0;
              er_on   <= 1'b1;
            end
          end
          PH_ARM_LOCK: begin
            mode_q <= RD_STATUS;
            phase  <= PH_IDLE;
            case (bus_wdata)
              OP_CONFIRM: begin
                if (master_q) begin
                  err.erase <= 1'b1;
                  err.lock  <= 1'b1;
                end else begin
                  lock_q <= '0;
                  phase  <= PH_RUN;
                  cnt    <= CNT_W'(LOCK_CYCLES - 1);
                end
              end
              OP_LOCK_SET: begin
                lock_q[map_blk] <= 1'b1;
                phase <= PH_RUN;
                cnt   <= CNT_W'(LOCK_CYCLES - 1);
              end
              OP_MASTER_SET: begin
                master_q <= 1'b1;
                phase    <= PH_RUN;
                cnt      <= CNT_W'(LOCK_CYCLES - 1);
              end
              default: begin
                err.erase <= 1'b1;
                err.prog  <= 1'b1;
              end
            endcase
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  // Array write port: erase sweep or program read-modify-write
  assign mem_we    = rmw2 | er_on;
  assign mem_waddr = er_on ? op_addr + ADDR_W'(er_ptr) : op_addr;
  assign mem_wdata = er_on ? 8'hFF : (mem_q & op_data);
  assign mem_raddr = busy ? op_addr : bus_addr;
  assign op_locked = lock_q[op_blk];

  always_comb begin
    status               = 8'h00;
    status[ST_READY]     = ~busy;
    status[ST_ERASE_ERR] = err.erase;
    status[ST_PROG_ERR]  = err.prog;
    status[ST_LOCK_ERR]  = err.lock;
  end

  assign mode        = mode_q;
  assign locks       = lock_q;
  assign master_lock = master_q;
  assign err_bits    = err;

endmodule

// File: rtl/pflash_rd_port.sv
module pflash_rd_port
  import pflash_cmd_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter logic [7:0]  MFR_ID = 8'hA7,
  parameter logic [7:0]  DEV_ID = 8'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  rd_mode_e          mode,
  input  logic [ADDR_W-1:0] off,
  input  logic              blk_locked,
  input  logic              master_lock,
  input  logic [7:0]        status,
  input  logic [7:0]        mem_q,
  output logic [7:0]        rdata,
  output logic              rvalid
);
  logic       v1, sel_arr;
  logic [7:0] info, id_byte;

  always_comb begin
    case (off)
      ADDR_W'(0): id_byte = MFR_ID;
      ADDR_W'(1): id_byte = DEV_ID;
      ADDR_W'(2): id_byte = {7'b0, blk_locked};
      ADDR_W'(3): id_byte = {7'b0, master_lock};
      default:    id_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1      <= 1'b0;
      sel_arr <= 1'b0;
      info    <= '0;
      rvalid  <= 1'b0;
      rdata   <= '0;
    end else begin
      v1      <= re;
      sel_arr <= (mode == RD_ARRAY);
      info    <= (mode == RD_STATUS) ? status : id_byte;
      rvalid  <= v1;
      if (v1) rdata <= sel_arr ? mem_q : info;
    end
  end

endmodule

// File: rtl/pflash_cmd_core.sv
module pflash_cmd_core
  import pflash_cmd_pkg::*;
#(
  parameter int         ADDR_W        = 8,
  parameter int         LARGE_SZ      = 64,
  parameter int         BOOT_LAYOUT   = 1,
  parameter int         PROG_CYCLES   = 5,
  parameter int         ERASE_TAIL    = 4,
  parameter int         LOCK_CYCLES   = 3,
  parameter int         LOCK_AT_RESET = 1,
  parameter logic [7:0] MFR_ID        = 8'hA7,
  parameter logic [7:0] DEV_ID        = 8'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid
);
  localparam int DEPTH     = 2 ** ADDR_W;
  localparam int NUM_LARGE = DEPTH / LARGE_SZ;
  localparam int NBLK      = (BOOT_LAYOUT != 0) ? NUM_LARGE + 7 : NUM_LARGE;
  localparam int BLK_W     = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam int LEN_W     = $clog2(LARGE_SZ) + 1;
  localparam int ER_MAX    = LARGE_SZ + ERASE_TAIL;
  localparam int MAXC      = (ER_MAX > PROG_CYCLES)
                             ? ((ER_MAX > LOCK_CYCLES) ? ER_MAX : LOCK_CYCLES)
                             : ((PROG_CYCLES > LOCK_CYCLES) ? PROG_CYCLES : LOCK_CYCLES);
  localparam int CNT_W     = $clog2(MAXC + 1);

  logic [BLK_W-1:0]  map_blk;
  logic [ADDR_W-1:0] map_base, map_off;
  logic [LEN_W-1:0]  map_len;
  logic [7:0]        mem_q, status_byte, mem_wdata;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic              mem_we, busy, armed, master_lock, op_locked;
  logic [NBLK-1:0]   locks;
  rd_mode_e          mode;
  err_t              err_bits;

  pflash_blk_map #(
    .ADDR_W(ADDR_W), .LARGE_SZ(LARGE_SZ), .BOOT_LAYOUT(BOOT_LAYOUT),
    .BLK_W(BLK_W), .LEN_W(LEN_W)
  ) u_map (
    .addr(bus_addr), .blk(map_blk), .base(map_base), .len(map_len), .off(map_off)
  );

  pflash_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_q)
  );

  pflash_ctrl #(
    .ADDR_W(ADDR_W), .NBLK(NBLK), .BLK_W(BLK_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_TAIL(ERASE_TAIL),
    .LOCK_CYCLES(LOCK_CYCLES), .LOCK_AT_RESET(LOCK_AT_RESET)
  ) u_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_addr(bus_addr), .map_blk(map_blk), .map_base(map_base),
    .map_len(map_len), .mem_q(mem_q), .mode(mode), .status(status_byte),
    .locks(locks), .master_lock(master_lock), .busy(busy), .armed(armed),
    .err_bits(err_bits), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_raddr(mem_raddr), .op_locked(op_locked)
  );

  pflash_rd_port #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
    .clk(clk), .rst(rst), .re(bus_re), .mode(mode), .off(map_off),
    .blk_locked(locks[map_blk]), .master_lock(master_lock),
    .status(status_byte), .mem_q(mem_q), .rdata(bus_rdata), .rvalid(bus_rvalid)
  );

endmodule

// File: rtl/pflash_cmd_checker.sv
module pflash_cmd_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_we,
  input logic       bus_re,
  input logic       bus_rvalid,
  input logic [7:0] bus_wdata,
  input logic       busy,
  input logic       armed,
  input logic       master_lock,
  input logic [2:0] err_bits,
  input logic       mem_we,
  input logic       op_locked
);
  // R2: read result two edges after the strobe
  p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
    bus_re |-> ##2 bus_rvalid);

  // R11: busy blocks every write from touching flags
  p_busy_ignores_r11: assert property (@(posedge clk) disable iff (rst)
    busy && bus_we |=> $stable(err_bits) && $stable(master_lock));

  // R7: master lock only cleared by reset
  p_master_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    master_lock |=> master_lock);

  // R8: no array write into a locked block
  p_no_locked_write_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !op_locked);

  // R6: array is only written during a busy operation
  p_write_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R10: clear-status empties the error flags
  p_clear_flags_r10: assert property (@(posedge clk) disable iff (rst)
    !busy && !armed && bus_we && bus_wdata == 8'h50 |=> err_bits == 3'b000);

endmodule

bind pflash_cmd_core pflash_cmd_checker u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
  .bus_rvalid(bus_rvalid), .bus_wdata(bus_wdata), .busy(busy), .armed(armed),
  .master_lock(master_lock), .err_bits(err_bits), .mem_we(mem_we),
  .op_locked(op_locked)
);

// File: tb/pflash_cmd_core_test.sv
module pflash_cmd_core_test;
  localparam int PROG_N  = 5;
  localparam int SMALL_N = 8 + 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  int         n_chk = 0;
  int         n_err = 0;

  always #10 clk = ~clk;

  pflash_cmd_core uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // All bus tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    @(negedge clk);
    d = bus_rvalid ? bus_rdata : 8'hxx;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic wait_ready(input string tag);
    logic [7:0] d;
    bit ok = 0;
    for (int i = 0; i < 300; i++) begin
      rd(8'h00, d);
      if (d[7] === 1'b1) begin ok = 1; break; end
    end
    if (!ok) check(tag, d, 8'h80);
  endtask

  task automatic t_reset();
    check("R1 rvalid idle", {7'b0, bus_rvalid}, 8'h00);
    rd_chk("R1 array mode after reset", 8'h00, 8'hFF);
    wr(8'h00, 8'h70);
    rd_chk("R1 R4 status after reset", 8'h00, 8'h80);
  endtask

  task automatic t_ident();
    logic [7:0] d;
    wr(8'h00, 8'h90);
    rd(8'h00, d);
    check("R3 manufacturer", d, 8'hA7);
    check("R3 odd parity", {7'b0, ^d}, 8'h01);
    rd_chk("R3 device", 8'h01, 8'h3C);
    rd_chk("R3 block1 lock", 8'h0A, 8'h01);
    rd_chk("R3 block9 lock", 8'h82, 8'h01);
    rd_chk("R3 master clear", 8'h03, 8'h00);
    rd_chk("R3 other offset", 8'h06, 8'h00);
    wr(8'h00, 8'hFF);
    rd_chk("R2 back to array", 8'h01, 8'hFF);
  endtask

  task automatic t_locked_ops();
    wr(8'h12, 8'h40); wr(8'h12, 8'h00);
    rd_chk("R8 program locked", 8'h00, 8'h92);
    wr(8'h00, 8'h50);
    rd_chk("R10 clear keeps status mode", 8'h00, 8'h80);
    wr(8'h00, 8'hFF);
    rd_chk("R8 array untouched", 8'h12, 8'hFF);
    wr(8'h40, 8'h20); wr(8'h47, 8'hD0);
    rd_chk("R8 erase locked", 8'h00, 8'hA2);
    wr(8'h00, 8'h50);
  endtask

  task automatic t_unlock();
    wr(8'h00, 8'h60); wr(8'h00, 8'hD0);
    wait_ready("R7 unlock ready");
    wr(8'h00, 8'h90);
    rd_chk("R7 block8 unlocked", 8'h42, 8'h00);
    rd_chk("R7 block1 unlocked", 8'h0A, 8'h00);
  endtask

  task automatic t_program();
    wr(8'h12, 8'h40); wr(8'h12, 8'hA5);
    repeat (PROG_N - 1) @(negedge clk);
    rd_chk("R11 busy at edge E+N", 8'h00, 8'h00);
    rd_chk("R11 ready after busy", 8'h00, 8'h80);
    wr(8'h00, 8'hFF);
    rd_chk("R5 programmed byte", 8'h12, 8'hA5);
    wr(8'h12, 8'h40); wr(8'h12, 8'h3C);
    wait_ready("R5 second program");
    wr(8'h00, 8'hFF);
    rd_chk("R5 bits only cleared", 8'h12, 8'h24);
    wr(8'h18, 8'h40); wr(8'h18, 8'h00);
    wait_ready("R5 neighbour program");
  endtask

  task automatic t_seq_err();
    wr(8'h12, 8'h20); wr(8'h12, 8'h33);
    rd_chk("R9 bad erase confirm", 8'h00, 8'hB0);
    wr(8'h00, 8'h50);
    wr(8'h00, 8'h60); wr(8'h00, 8'h77);
    rd_chk("R9 bad lock confirm", 8'h00, 8'hB0);
    wr(8'h00, 8'h50);
    wr(8'h00, 8'hFF);
    rd_chk("R9 array unchanged", 8'h12, 8'h24);
  endtask

  task automatic t_erase_small();
    wr(8'h13, 8'h20); wr(8'h15, 8'hD0);
    wr(8'h00, 8'hFF); wr(8'h00, 8'h90);
    repeat (SMALL_N - 2) @(negedge clk);
    rd_chk("R11 ready at E+N+1, writes ignored", 8'h00, 8'h80);
    wr(8'h00, 8'hFF);
    rd_chk("R6 erased byte", 8'h12, 8'hFF);
    rd_chk("R6 block start", 8'h10, 8'hFF);
    rd_chk("R12 next small block kept", 8'h18, 8'h00);
  endtask

  task automatic t_erase_large();
    wr(8'h81, 8'h40); wr(8'h81, 8'h00);
    wait_ready("R6 prep 81");
    wr(8'hC0, 8'h40); wr(8'hC0, 8'h00);
    wait_ready("R6 prep C0");
    wr(8'h90, 8'h20); wr(8'hBF, 8'hD0);
    wait_ready("R6 large erase");
    wr(8'h00, 8'hFF);
    rd_chk("R6 large block erased", 8'h81, 8'hFF);
    rd_chk("R12 next large block kept", 8'hC0, 8'h00);
  endtask

  task automatic t_lock_set();
    wr(8'h40, 8'h60); wr(8'h45, 8'h01);
    wait_ready("R7 set lock");
    wr(8'h00, 8'h60); wr(8'h00, 8'hF1);
    wait_ready("R7 set master");
    wr(8'h00, 8'h90);
    rd_chk("R7 block8 locked", 8'h42, 8'h01);
    rd_chk("R7 master set", 8'h03, 8'h01);
    rd_chk("R7 block9 still unlocked", 8'h82, 8'h00);
    wr(8'h00, 8'h60); wr(8'h00, 8'hD0);
    rd_chk("R7 unlock refused", 8'h00, 8'hA2);
    wr(8'h00, 8'h50);
    wr(8'h00, 8'h90);
    rd_chk("R7 lock kept", 8'h42, 8'h01);
    wr(8'h44, 8'h40); wr(8'h44, 8'h00);
    rd_chk("R8 program relocked block", 8'h00, 8'h92);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ident();
    t_locked_ops();
    t_unlock();
    t_program();
    t_seq_err();
    t_erase_small();
    t_erase_large();
    t_lock_set();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule